// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block lives inside a two-wire target and handles the read of the SMBus Alert Response Address. It gets bus events that have already been decoded into single-cycle pulses: START, STOP, SCL rising edge and SCL falling edge. It also gets the sampled SDA level. The block shifts in the first byte after START itself. If that byte is the alert-response read and the local alert is active, the block acknowledges it. It then shifts out its own 7-bit address followed by a cause bit. While it does so it arbitrates bit by bit against any other responder, using the wired-AND SDA line.

The alert pin is active-low and open-drain. The block models it as a drive-enable (`alert_oe`). When the block finishes a response without losing arbitration, it pulses `alert_clear` on the closing STOP or repeated START. It also withdraws the pin until the external pending flag drops. A responder that loses arbitration keeps its pin asserted so that the master asks again.

The controlling state machine has seven states:
- IDLE waits for a START.
- CMD shifts in the command byte and moves to DECIDE on the eighth SCL rise.
- DECIDE moves on the next SCL fall: to ACK if the byte matched and the alert is active, otherwise to HOLD.
- ACK pulls SDA low and moves to SEND on the next SCL fall.
- SEND shifts out the response. It moves to HOLD on lost arbitration, or to DONE after the eighth bit ends.
- DONE waits for the bus to close.
- HOLD stays silent until the next START.

From any state, a START moves to CMD and a STOP moves to IDLE.

Top module: `smb_alert_responder`

## Requirements
- R1: After reset `sda_oe` and `alert_clear` are 0 and the block is idle.
- R2: `alert_oe` is 1 exactly while `alert_pending` is 1 and no win has been recorded since `alert_pending` last rose.
- R3: The first byte after START is sampled MSB first on SCL rises. If it equals 0x19 and the alert is active, `sda_oe` is 1 during the ninth (acknowledge) bit.
- R4: Any other first byte (0x18 included), or an inactive alert, gives no acknowledge. `sda_oe` then stays 0 until the next START.
- R5: After the acknowledge, the block sends 8 bits MSB first. Bits 7..1 carry `own_addr` bit 6..0, and bit 0 is the cause bit. A 0 is sent by setting `sda_oe`=1 and a 1 by releasing the line.
- R6: The cause bit equals `cause_low` XOR `polarity`. `cause_low` is 1 when the reading is below the low limit and 0 when it is at or above the high limit.
- R7: On each of the 7 address bits, if the block releases SDA but samples 0 on the SCL rise, it has lost. It then keeps `sda_oe` at 0 until the next START, so the lowest address wins.
- R8: A block that sent all 8 response bits pulses `alert_clear` for one cycle on the next STOP or START. From the following cycle `alert_oe` is 0 until `alert_pending` falls.
- R9: A block that lost arbitration gives no `alert_clear` pulse and keeps `alert_oe` at 1.
- R10: `sda_oe` changes only in the cycle after an SCL fall, START or STOP event, never while SCL is high.
- R11: After a win, while `alert_pending` is still 1, a new 0x19 command is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_evt | input | 1 | START or repeated START seen (one-cycle pulse) |
| stop_evt | input | 1 | STOP seen (one-cycle pulse) |
| scl_rise | input | 1 | SCL rising edge (one-cycle pulse) |
| scl_fall | input | 1 | SCL falling edge (one-cycle pulse) |
| sda_in | input | 1 | Sampled SDA bus level |
| own_addr | input | 7 | This target's bus address |
| alert_pending | input | 1 | Alert condition raised by the device |
| cause_low | input | 1 | 1 = below low limit, 0 = at or above high limit |
| polarity | input | 1 | Inverts the cause bit when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| alert_oe | output | 1 | Pull alert pin low when 1 |
| alert_clear | output | 1 | One-cycle pulse: the alert response was won |

## Verification
A wrong state-machine state shows at the SDA enable within one bit time. An acknowledge that is missing or extra shows in the ninth bit. A misplaced or inverted response bit shows in the bit where it differs. A responder that keeps driving after a loss shows as SDA pulled low on a bit it no longer owns. A wrong win record shows at the closing STOP as a missing or extra `alert_clear` pulse and a wrong `alert_oe` level on the next cycle. A stale suppression latch shows only at the next command, as a wrong acknowledge.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_DECIDE,
        ST_ACK,
        ST_SEND,
        ST_DONE,
        ST_HOLD
    } sar_state_e;

    localparam logic [7:0] ARA_READ_BYTE = 8'h19;

endpackage

// File: rtl/sar_rx_shift.sv
module sar_rx_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              en,
    input  logic              scl_rise,
    input  logic              sda_in,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_val
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (clear) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (en && scl_rise) begin
            shreg <= {shreg[BYTE_W-2:0], sda_in};
            cnt   <= (cnt == LAST_BIT) ? '0 : cnt + 1'b1;
        end
    end

    // Completed byte is offered in the same cycle as its last rise.
    assign byte_done = en && scl_rise && (cnt == LAST_BIT);
    assign byte_val  = {shreg[BYTE_W-2:0], sda_in};

    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_BIT);

endmodule

// File: rtl/sar_tx_arb.sv
module sar_tx_arb #(
    parameter int BYTE_W   = 8,
    parameter int ARB_BITS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_val,
    input  logic              en,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_in,
    output logic              drive_low,
    output logic              lost,
    output logic              last_done
);
    localparam int IDX_W = $clog2(BYTE_W);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(BYTE_W - 1);
    localparam logic [IDX_W-1:0] ARB_LO  = IDX_W'(BYTE_W - ARB_BITS);

    logic [BYTE_W-1:0] data_q;
    logic [IDX_W-1:0]  idx;
    logic              cur_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '1;
            idx    <= TOP_IDX;
        end else if (load) begin
            data_q <= load_val;
            idx    <= TOP_IDX;
        end else if (en && scl_fall && idx != '0) begin
            idx <= idx - 1'b1;
        end
    end

    assign cur_bit   = data_q[idx];
    assign drive_low = en && !cur_bit;
    // Released a one, bus shows zero: someone with a lower code is talking.
    assign lost      = en && scl_rise && (idx >= ARB_LO) && cur_bit && !sda_in;
    assign last_done = en && scl_fall && (idx == '0);

    p_lost_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lost |-> !drive_low);

endmodule

// File: rtl/sar_alert_ctl.sv
module sar_alert_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic alert_pending,
    input  logic win,
    output logic alert_active,
    output logic alert_oe
);
    logic suppress;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              suppress <= 1'b0;
        else if (!alert_pending) suppress <= 1'b0;
        else if (win)            suppress <= 1'b1;
    end

    assign alert_active = alert_pending && !suppress;
    assign alert_oe     = alert_active;

    p_win_withdraws_r8: assert property (@(posedge clk) disable iff (!rst_n)
        win |=> !alert_oe);

    p_no_alert_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !alert_pending |-> !alert_oe);

endmodule

// File: rtl/smb_alert_responder.sv
module smb_alert_responder
    import sar_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_in,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              alert_pending,
    input  logic              cause_low,
    input  logic              polarity,
    output logic              sda_oe,
    output logic              alert_oe,
    output logic              alert_clear
);
    localparam int BYTE_W = ADDR_W + 1;

    sar_state_e        state, nxt;
    logic              ack_go;
    logic              byte_done;
    logic [BYTE_W-1:0] byte_val;
    logic              tx_load, tx_drive, tx_lost, tx_last;
    logic              alert_active;

    sar_rx_shift #(.BYTE_W(BYTE_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start_evt),
        .en        (state == ST_CMD),
        .scl_rise  (scl_rise),
        .sda_in    (sda_in),
        .byte_done (byte_done),
        .byte_val  (byte_val)
    );

    sar_tx_arb #(.BYTE_W(BYTE_W), .ARB_BITS(ADDR_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tx_load),
        .load_val  ({own_addr, cause_low ^ polarity}),
        .en        (state == ST_SEND),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_in    (sda_in),
        .drive_low (tx_drive),
        .lost      (tx_lost),
        .last_done (tx_last)
    );

    sar_alert_ctl u_alert (
        .clk           (clk),
        .rst_n         (rst_n),
        .alert_pending (alert_pending),
        .win           (alert_clear),
        .alert_active  (alert_active),
        .alert_oe      (alert_oe)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            ack_go <= 1'b0;
        end else begin
            state <= nxt;
            if (byte_done)
                ack_go <= (byte_val == BYTE_W'(ARA_READ_BYTE)) && alert_active;
        end
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   nxt = state;
            ST_CMD:    if (byte_done) nxt = ST_DECIDE;
            ST_DECIDE: if (scl_fall)  nxt = ack_go ? ST_ACK : ST_HOLD;
            ST_ACK:    if (scl_fall)  nxt = ST_SEND;
            ST_SEND: begin
                if (tx_lost)      nxt = ST_HOLD;
                else if (tx_last) nxt = ST_DONE;
            end
            ST_DONE:   nxt = state;
            ST_HOLD:   nxt = state;
            default:   nxt = ST_IDLE;
        endcase
        if (start_evt)     nxt = ST_CMD;
        else if (stop_evt) nxt = ST_IDLE;
    end

    // Outputs
    always_comb begin
        tx_load     = (state == ST_ACK) && scl_fall;
        sda_oe      = (state == ST_ACK) || ((state == ST_SEND) && tx_drive);
        alert_clear = (state == ST_DONE) && (start_evt || stop_evt);
    end

    p_sda_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(scl_fall || start_evt || stop_evt));

    p_hold_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> !sda_oe);

    p_lost_stays_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_lost && !start_evt) |=> !sda_oe);

    p_clear_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        alert_clear |-> !sda_oe);

endmodule

// File: tb/tb_smb_alert_responder.sv
module tb_smb_alert_responder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_evt = 1'b0, stop_evt = 1'b0;
    logic       scl_rise = 1'b0, scl_fall = 1'b0;
    logic       sda_in = 1'b1;
    logic [6:0] own_addr = 7'h48;
    logic       alert_pending = 1'b0, cause_low = 1'b0, polarity = 1'b0;
    logic       sda_oe, alert_oe, alert_clear;

    int  errors = 0;
    int  checks = 0;
    bit  sup = 1'b0;
    bit  finished = 1'b0;
    int  r10_bad = 0;

    always #10 clk = ~clk;

    smb_alert_responder dut (
        .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in),
        .own_addr(own_addr), .alert_pending(alert_pending),
        .cause_low(cause_low), .polarity(polarity),
        .sda_oe(sda_oe), .alert_oe(alert_oe), .alert_clear(alert_clear)
    );

    // R10 monitor: event seen at the last edge, SDA enable change after it
    logic ev_q = 1'b0;
    logic oe_prev = 1'b0;
    always @(posedge clk) ev_q <= start_evt | stop_evt | scl_fall;
    always @(negedge clk) begin
        if (rst_n && sda_oe !== oe_prev && !ev_q) r10_bad++;
        oe_prev <= sda_oe;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] resp_byte(input logic [6:0] a, input logic c, input logic p);
        return {a, c ^ p};
    endfunction

    task automatic bus_bit(input logic mbit, input logic oth_low, output logic seen);
        @(negedge clk);
        seen = mbit & ~sda_oe & ~oth_low;
        sda_in = seen; scl_rise = 1'b1;
        @(negedge clk); scl_rise = 1'b0;
        @(negedge clk); scl_fall = 1'b1;
        @(negedge clk); scl_fall = 1'b0;
    endtask

    task automatic txn(input logic [7:0] cmd, input logic [6:0] own, input logic cl,
                       input logic pl, input bit oth_on, input logic [6:0] oth_addr,
                       input logic oth_c);
        logic       seen;
        logic [7:0] db, ob;
        bit         exp_ack, dut_lost, oth_lost, bits_ok, exp_win;
        logic [7:0] got;
        logic       clr;
        string      tag;
        own_addr = own; cause_low = cl; polarity = pl;
        db = resp_byte(own, cl, pl);
        ob = {oth_addr, oth_c};
        @(negedge clk); start_evt = 1'b1; sda_in = 1'b0;
        @(negedge clk); start_evt = 1'b0;
        for (int i = 7; i >= 0; i--) bus_bit(cmd[i], 1'b0, seen);
        exp_ack = (cmd == 8'h19) && alert_pending && !sup;
        tag = exp_ack ? "R3" : ((cmd == 8'h19 && alert_pending) ? "R11" : "R4");
        check(sda_oe == exp_ack, tag, sda_oe, exp_ack);
        bus_bit(1'b1, 1'b0, seen);
        dut_lost = 1'b0; oth_lost = 1'b0; bits_ok = 1'b1; got = '0;
        for (int i = 7; i >= 0; i--) begin
            logic exp_drv, oth_low;
            exp_drv = exp_ack && !dut_lost && !db[i];
            oth_low = oth_on && !oth_lost && !ob[i];
            got[i] = sda_oe;
            if (sda_oe !== exp_drv) bits_ok = 1'b0;
            bus_bit(1'b1, oth_low, seen);
            if (i >= 1 && exp_ack && !dut_lost && db[i] && !seen) dut_lost = 1'b1;
            if (i >= 1 && oth_on && !oth_lost && ob[i] && !seen) oth_lost = 1'b1;
        end
        tag = !exp_ack ? "R4" : (oth_on ? "R7" : "R5");
        check(bits_ok, tag, got, exp_ack ? ~db : 8'h00);
        check(sda_oe == 1'b0, "R5", sda_oe, 0);
        bus_bit(1'b1, 1'b0, seen);
        exp_win = exp_ack && !dut_lost;
        @(negedge clk); stop_evt = 1'b1; sda_in = 1'b1;
        #1 clr = alert_clear;
        @(negedge clk); stop_evt = 1'b0;
        if (exp_win) sup = 1'b1;
        #1;
        tag = exp_win ? "R8" : (exp_ack ? "R9" : "R2");
        check(clr == exp_win, tag, clr, exp_win);
        check(alert_oe == (alert_pending && !sup), tag, alert_oe, alert_pending && !sup);
    endtask

    task automatic set_pending(input logic v);
        @(negedge clk); alert_pending = v;
        if (!v) sup = 1'b0;
        @(negedge clk); @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        #1;
        check(sda_oe == 1'b0 && alert_clear == 1'b0, "R1", {sda_oe, alert_clear}, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(sda_oe == 1'b0 && alert_oe == 1'b0, "R1", {sda_oe, alert_oe}, 0);

        // R2: pin follows pending flag
        set_pending(1'b1);
        check(alert_oe == 1'b1, "R2", alert_oe, 1);

        // R5/R6/R8: lone responder, cause below low limit, polarity 0
        txn(8'h19, 7'h48, 1'b1, 1'b0, 1'b0, 7'h00, 1'b0);
        // R11: suppressed, no acknowledge
        txn(8'h19, 7'h48, 1'b1, 1'b0, 1'b0, 7'h00, 1'b0);
        set_pending(1'b0);
        check(alert_oe == 1'b0, "R2", alert_oe, 0);
        set_pending(1'b1);
        check(alert_oe == 1'b1, "R2", alert_oe, 1);

        // R7/R9: lower address elsewhere wins
        txn(8'h19, 7'h48, 1'b0, 1'b0, 1'b1, 7'h40, 1'b1);
        // R6: polarity inverts cause, higher rival loses
        txn(8'h19, 7'h48, 1'b1, 1'b1, 1'b1, 7'h4A, 1'b0);
        set_pending(1'b0); set_pending(1'b1);
        // R6: at or above high limit, polarity 1
        txn(8'h19, 7'h33, 1'b0, 1'b1, 1'b0, 7'h00, 1'b0);
        set_pending(1'b0); set_pending(1'b1);
        // R4: write-direction byte and unrelated byte
        txn(8'h18, 7'h48, 1'b0, 1'b0, 1'b0, 7'h00, 1'b0);
        txn(8'h90, 7'h48, 1'b0, 1'b0, 1'b0, 7'h00, 1'b0);
        // R4: alert inactive
        set_pending(1'b0);
        txn(8'h19, 7'h48, 1'b0, 1'b0, 1'b0, 7'h00, 1'b0);

        for (int n = 0; n < 60; n++) begin
            logic [6:0] a, b;
            logic [7:0] c;
            a = 7'($urandom);
            b = 7'($urandom);
            if (b == a) b = a ^ 7'h01;
            c = ($urandom % 5 == 0) ? 8'($urandom) : 8'h19;
            set_pending(1'b0);
            set_pending(($urandom % 6) != 0);
            txn(c, a, 1'($urandom), 1'($urandom), 1'($urandom), b, 1'($urandom));
        end

        check(r10_bad == 0, "R10", r10_bad, 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule